// File: doc/BRIEF.md
# Recent-Retire Hot Address Tracker

This block watches the stream of retired program counters from a processor core. It keeps only the latest `DEPTH` addresses in a circular buffer, and each new retire replaces the oldest one. Nothing is counted while the core runs. When a trigger pulse arrives, the block freezes the buffer and scans it sequentially. It then reports the address that occurs most often, how many times it occurs, and how many entries took part. The usual case is a program that has stopped making progress: a debug controller fires the trigger, and the reported address shows the spin loop the program is stuck in.

The block also keeps a free-running count of every retire since reset. This count is reported separately from the ring. The ring occupancy is visible at all times. A one-cycle done pulse marks the moment the scan result becomes valid.

Top module: `hot_pc_tracker`

## Requirements
- R1: The ring holds the `DEPTH` (default 256) most recently accepted PCs. Once the ring is full, each accepted retire overwrites the oldest entry, and older history plays no part in any result.
- R2: On completion of a scan, `hot_pc_o` is the PC that occurs most often among the snapshot entries, and `hot_cnt_o` is its number of occurrences.
- R3: The result is computed only in response to `trig_i`. `hot_pc_o`, `hot_cnt_o` and `hot_size_o` change only in the cycle where `done_o` is high, and they hold their values otherwise.
- R4: `hot_size_o` is the number of entries scanned. With a full ring fed by a two-address loop that retires both addresses alternately, the result is a count of 128 against a size of 256.
- R5: `retire_total_o` increments by one on every cycle with `ret_valid_i` high, including cycles during a scan. It wraps modulo 2^`TOT_W`.
- R6: The scan runs from the oldest entry to the newest. On a tie the entry scanned first wins, which is the candidate whose first occurrence is oldest.
- R7: `ring_fill_o` counts accepted retires and saturates at `DEPTH`. With a ring that is not full, only the filled entries are scanned and `hot_size_o` equals the fill.
- R8: A retire is not stored if it arrives in the trigger cycle or while a scan is running. A trigger that arrives during a scan is ignored. A second trigger with no new retires in between returns the identical result.
- R9: `done_o` is a single-cycle pulse. For a snapshot of F entries it rises F×(F+1) clock edges after the edge that sampled the trigger.
- R10: Reset clears the ring fill, the retire total, all result outputs and `done_o`.
- R11: A trigger on an empty ring raises `done_o` at the sampling edge itself, with the PC, count and size all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid_i | input | 1 | A PC retired this cycle |
| ret_pc_i | input | 32 | Retired PC |
| trig_i | input | 1 | Start a scan of the ring |
| hot_pc_o | output | 32 | Most frequent PC of the last scan |
| hot_cnt_o | output | 9 | Occurrences of `hot_pc_o` |
| hot_size_o | output | 9 | Entries taken into the last scan |
| ring_fill_o | output | 9 | Current ring occupancy |
| done_o | output | 1 | One-cycle pulse: scan result valid |
| retire_total_o | output | 32 | Retires since reset |

## Verification
A bad write pointer or fill counter cannot be seen as a wrong number right away. It first shows up at the next `done_o`, as a mode or size that disagrees with a plain queue of the last accepted PCs. The only exception is the occupancy output, which drifts on the very next cycle. A faulty scan controller shows up as a pulse at the wrong edge, a missing pulse, or outputs that move without a pulse. All of these are visible within the F×(F+1) window of the scan. Tie order and the handling of retires during a scan only affect a later result, so the bench triggers twice in a row and uses deliberately tied patterns to expose them.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_LOAD = 2'd1,
    SC_CMP  = 2'd2
  } scan_state_e;

endpackage

// File: rtl/hpt_ring.sv
module hpt_ring #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [IDX_W-1:0] rd_idx_a_i,
  output logic [PC_W-1:0]  rd_pc_a_o,
  input  logic [IDX_W-1:0] rd_idx_b_i,
  output logic [PC_W-1:0]  rd_pc_b_o,
  output logic [IDX_W-1:0] wr_ptr_o,
  output logic [CNT_W-1:0] fill_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_C  = IDX_W'(DEPTH - 1);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             ptr_en, fill_en;

  // storage has no reset: only filled entries are ever read
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[ptr_q] <= wr_pc_i;
    end
  end

  always_comb begin
    ptr_en  = wr_en_i;
    ptr_d   = (ptr_q == LAST_C) ? '0 : ptr_q + 1'b1;
    fill_en = wr_en_i && (fill_q != DEPTH_C);
    fill_d  = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (fill_en) fill_q <= fill_d;
    end
  end

  assign rd_pc_a_o = mem_q[rd_idx_a_i];
  assign rd_pc_b_o = mem_q[rd_idx_b_i];
  assign wr_ptr_o  = ptr_q;
  assign fill_o    = fill_q;

endmodule

// File: rtl/hpt_scan.sv
module hpt_scan
  import hpt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [IDX_W-1:0] wr_ptr_i,
  output logic [IDX_W-1:0] rd_idx_a_o,
  input  logic [PC_W-1:0]  rd_pc_a_i,
  output logic [IDX_W-1:0] rd_idx_b_o,
  input  logic [PC_W-1:0]  rd_pc_b_i,
  output logic             busy_o,
  output logic [PC_W-1:0]  res_pc_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic [CNT_W-1:0] res_size_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [IDX_W:0]   DEPTH_X = (IDX_W + 1)'(DEPTH);

  scan_state_e      st_q, st_d;
  logic [CNT_W-1:0] k_q, k_d;
  logic [CNT_W-1:0] m_q, m_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic [IDX_W-1:0] base_q, base_d;
  logic [PC_W-1:0]  cand_q, cand_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] best_cnt_q, best_cnt_d;
  logic [PC_W-1:0]  best_pc_q, best_pc_d;
  logic [PC_W-1:0]  res_pc_q, res_pc_d;
  logic [CNT_W-1:0] res_cnt_q, res_cnt_d;
  logic [CNT_W-1:0] res_size_q, res_size_d;
  logic             done_q, done_d;
  logic             res_en;

  logic [IDX_W:0]   sum_k, sum_m;
  logic             hit, last_m, last_k, better;
  logic [CNT_W-1:0] tally;

  // logical position k / m from the oldest entry mapped to a physical slot
  always_comb begin
    sum_k = {1'b0, base_q} + {1'b0, k_q[IDX_W-1:0]};
    sum_m = {1'b0, base_q} + {1'b0, m_q[IDX_W-1:0]};
    rd_idx_a_o = (sum_k >= DEPTH_X) ? IDX_W'(sum_k - DEPTH_X) : IDX_W'(sum_k);
    rd_idx_b_o = (sum_m >= DEPTH_X) ? IDX_W'(sum_m - DEPTH_X) : IDX_W'(sum_m);
  end

  always_comb begin
    hit    = (rd_pc_b_i == cand_q);
    tally  = run_q + CNT_W'(hit);
    last_m = (m_q == snap_q - 1'b1);
    last_k = (k_q == snap_q - 1'b1);
    better = (tally > best_cnt_q);
  end

  always_comb begin
    st_d       = st_q;
    k_d        = k_q;
    m_d        = m_q;
    snap_d     = snap_q;
    base_d     = base_q;
    cand_d     = cand_q;
    run_d      = run_q;
    best_cnt_d = best_cnt_q;
    best_pc_d  = best_pc_q;
    res_pc_d   = res_pc_q;
    res_cnt_d  = res_cnt_q;
    res_size_d = res_size_q;
    res_en     = 1'b0;
    done_d     = 1'b0;
    unique case (st_q)
      SC_IDLE: begin
        if (trig_i) begin
          if (fill_i == '0) begin
            res_en     = 1'b1;
            res_pc_d   = '0;
            res_cnt_d  = '0;
            res_size_d = '0;
            done_d     = 1'b1;
          end else begin
            snap_d     = fill_i;
            base_d     = (fill_i == DEPTH_C) ? wr_ptr_i : '0;
            k_d        = '0;
            best_cnt_d = '0;
            best_pc_d  = '0;
            st_d       = SC_LOAD;
          end
        end
      end
      SC_LOAD: begin
        cand_d = rd_pc_a_i;
        m_d    = '0;
        run_d  = '0;
        st_d   = SC_CMP;
      end
      SC_CMP: begin
        if (last_m) begin
          if (better) begin
            best_cnt_d = tally;
            best_pc_d  = cand_q;
          end
          if (last_k) begin
            res_en     = 1'b1;
            res_pc_d   = better ? cand_q : best_pc_q;
            res_cnt_d  = better ? tally  : best_cnt_q;
            res_size_d = snap_q;
            done_d     = 1'b1;
            st_d       = SC_IDLE;
          end else begin
            k_d  = k_q + 1'b1;
            st_d = SC_LOAD;
          end
        end else begin
          run_d = tally;
          m_d   = m_q + 1'b1;
        end
      end
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SC_IDLE;
      k_q        <= '0;
      m_q        <= '0;
      snap_q     <= '0;
      base_q     <= '0;
      cand_q     <= '0;
      run_q      <= '0;
      best_cnt_q <= '0;
      best_pc_q  <= '0;
      res_pc_q   <= '0;
      res_cnt_q  <= '0;
      res_size_q <= '0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      k_q        <= k_d;
      m_q        <= m_d;
      snap_q     <= snap_d;
      base_q     <= base_d;
      cand_q     <= cand_d;
      run_q      <= run_d;
      best_cnt_q <= best_cnt_d;
      best_pc_q  <= best_pc_d;
      done_q     <= done_d;
      if (res_en) begin
        res_pc_q   <= res_pc_d;
        res_cnt_q  <= res_cnt_d;
        res_size_q <= res_size_d;
      end
    end
  end

  assign busy_o     = (st_q != SC_IDLE);
  assign res_pc_o   = res_pc_q;
  assign res_cnt_o  = res_cnt_q;
  assign res_size_o = res_size_q;
  assign done_o     = done_q;

endmodule

// File: rtl/hpt_retire_total.sv
module hpt_retire_total #(
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [TOT_W-1:0] total_o
);

  logic [TOT_W-1:0] tot_q, tot_d;
  logic             tot_en;

  always_comb begin
    tot_en = inc_i;
    tot_d  = tot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
    end else if (tot_en) begin
      tot_q <= tot_d;
    end
  end

  assign total_o = tot_q;

endmodule

// File: rtl/hot_pc_tracker.sv
module hot_pc_tracker #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 256,
  parameter int TOT_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid_i,
  input  logic [PC_W-1:0]  ret_pc_i,
  input  logic             trig_i,
  output logic [PC_W-1:0]  hot_pc_o,
  output logic [CNT_W-1:0] hot_cnt_o,
  output logic [CNT_W-1:0] hot_size_o,
  output logic [CNT_W-1:0] ring_fill_o,
  output logic             done_o,
  output logic [TOT_W-1:0] retire_total_o
);

  logic             scan_busy;
  logic             ring_wr;
  logic [IDX_W-1:0] idx_a, idx_b, wr_ptr;
  logic [PC_W-1:0]  pc_a, pc_b;
  logic [CNT_W-1:0] fill;

  // the trigger cycle and the whole scan keep the snapshot frozen
  assign ring_wr = ret_valid_i && !scan_busy && !trig_i;

  hpt_ring #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (ring_wr),
    .wr_pc_i    (ret_pc_i),
    .rd_idx_a_i (idx_a),
    .rd_pc_a_o  (pc_a),
    .rd_idx_b_i (idx_b),
    .rd_pc_b_o  (pc_b),
    .wr_ptr_o   (wr_ptr),
    .fill_o     (fill)
  );

  hpt_scan #(.PC_W(PC_W), .DEPTH(DEPTH)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .fill_i     (fill),
    .wr_ptr_i   (wr_ptr),
    .rd_idx_a_o (idx_a),
    .rd_pc_a_i  (pc_a),
    .rd_idx_b_o (idx_b),
    .rd_pc_b_i  (pc_b),
    .busy_o     (scan_busy),
    .res_pc_o   (hot_pc_o),
    .res_cnt_o  (hot_cnt_o),
    .res_size_o (hot_size_o),
    .done_o     (done_o)
  );

  hpt_retire_total #(.TOT_W(TOT_W)) u_total (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (ret_valid_i),
    .total_o (retire_total_o)
  );

  assign ring_fill_o = fill;

endmodule

// File: rtl/hpt_checker.sv
module hpt_checker #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 256,
  parameter int TOT_W = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid_i,
  input logic             busy,
  input logic [PC_W-1:0]  hot_pc_o,
  input logic [CNT_W-1:0] hot_cnt_o,
  input logic [CNT_W-1:0] hot_size_o,
  input logic [CNT_W-1:0] ring_fill_o,
  input logic             done_o,
  input logic [TOT_W-1:0] retire_total_o
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hot_pc_o) && $stable(hot_cnt_o) && $stable(hot_size_o)));

  a_r2_count_in_size: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((hot_cnt_o <= hot_size_o) && ((hot_cnt_o == '0) == (hot_size_o == '0))));

  a_r7_fill_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ring_fill_o <= CNT_W'(DEPTH));

  a_r7_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_fill_o == $past(ring_fill_o)) || (ring_fill_o == $past(ring_fill_o) + 1'b1));

  a_r8_frozen_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ring_fill_o));

  a_r5_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_i |=> (retire_total_o == $past(retire_total_o) + 1'b1));

  a_r5_total_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid_i |=> $stable(retire_total_o));

endmodule

bind hot_pc_tracker hpt_checker #(.PC_W(PC_W), .DEPTH(DEPTH), .TOT_W(TOT_W)) u_hpt_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .ret_valid_i    (ret_valid_i),
  .busy           (scan_busy),
  .hot_pc_o       (hot_pc_o),
  .hot_cnt_o      (hot_cnt_o),
  .hot_size_o     (hot_size_o),
  .ring_fill_o    (ring_fill_o),
  .done_o         (done_o),
  .retire_total_o (retire_total_o)
);

// File: tb/hot_pc_tracker_bench.sv
`timescale 1ns/1ps
module hot_pc_tracker_bench;

  localparam int DEPTH = 256;

  logic        clk;
  logic        rst_n;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic        trig;
  logic [31:0] hot_pc;
  logic [8:0]  hot_cnt, hot_size, ring_fill;
  logic        done;
  logic [31:0] total;

  hot_pc_tracker u_hot_pc_tracker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ret_valid_i    (ret_valid),
    .ret_pc_i       (ret_pc),
    .trig_i         (trig),
    .hot_pc_o       (hot_pc),
    .hot_cnt_o      (hot_cnt),
    .hot_size_o     (hot_size),
    .ring_fill_o    (ring_fill),
    .done_o         (done),
    .retire_total_o (total)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [31:0] q[$];
  int          m_total;
  bit          m_busy;
  int          m_lat;
  int          e_lat;
  logic [31:0] e_pc, h_pc;
  int          e_cnt, e_size, h_cnt, h_size;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // mode of the queue, oldest first, strictly-greater replaces the best
  function automatic void model_scan();
    e_pc = '0; e_cnt = 0; e_size = q.size();
    for (int k = 0; k < q.size(); k++) begin
      int c = 0;
      for (int m = 0; m < q.size(); m++) if (q[m] == q[k]) c++;
      if (c > e_cnt) begin e_cnt = c; e_pc = q[k]; end
    end
    e_lat = e_size * (e_size + 1);
  endfunction

  task automatic model_edge(input logic v, input logic [31:0] pc, input logic t);
    if (v) m_total++;
    if (!m_busy) begin
      if (t) begin
        m_busy = 1'b1; m_lat = 0; model_scan();
      end else if (v) begin
        q.push_back(pc);
        if (q.size() > DEPTH) void'(q.pop_front());
      end
    end else begin
      m_lat++;
    end
  endtask

  task automatic compare(input string tag);
    chk(ring_fill == 9'(q.size()), "R7", {tag, " ring_fill"}, ring_fill, q.size());
    chk(total == 32'(m_total), "R5", {tag, " retire_total"}, total, m_total);
    if (done) begin
      chk(m_busy, "R9", {tag, " unexpected done"}, done, 0);
      if (m_busy) begin
        chk(hot_pc == e_pc, "R2", {tag, " hot_pc"}, hot_pc, e_pc);
        chk(hot_cnt == 9'(e_cnt), "R2", {tag, " hot_cnt"}, hot_cnt, e_cnt);
        chk(hot_size == 9'(e_size), "R4", {tag, " hot_size"}, hot_size, e_size);
        chk(m_lat == e_lat, "R9", {tag, " done latency"}, m_lat, e_lat);
        h_pc = e_pc; h_cnt = e_cnt; h_size = e_size;
        m_busy = 1'b0;
      end
    end else begin
      chk(hot_pc == h_pc && hot_cnt == 9'(h_cnt) && hot_size == 9'(h_size),
          "R3", {tag, " result held"}, hot_cnt, h_cnt);
    end
  endtask

  // called at a falling edge: drive, take the rising edge, check at next fall
  task automatic cyc(input logic v, input logic [31:0] pc, input logic t, input string tag);
    ret_valid = v; ret_pc = pc; trig = t;
    @(posedge clk);
    model_edge(v, pc, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    while (m_busy && guard < 70000) begin
      cyc(1'b0, '0, 1'b0, tag);
      guard++;
    end
    chk(!m_busy, "R9", {tag, " done seen"}, m_busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ret_valid = 1'b0; ret_pc = '0; trig = 1'b0;
    repeat (3) @(negedge clk);
    q.delete(); m_total = 0; m_busy = 1'b0;
    h_pc = '0; h_cnt = 0; h_size = 0;
    chk(ring_fill == 0 && total == 0 && done == 1'b0, "R10", "fill/total/done in reset",
        {ring_fill, total}, 0);
    chk(hot_pc == 0 && hot_cnt == 0 && hot_size == 0, "R10", "results in reset", hot_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 180000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] set3[7];
    do_reset();

    // R11: empty ring
    cyc(1'b0, '0, 1'b1, "R11 empty");
    chk(m_busy == 1'b0, "R11", "empty trigger done at sampling edge", m_busy, 0);

    // R2 / R7: partial fill, mode 0x..08 three times
    set3 = '{32'h8010_0000, 32'h8010_0008, 32'h8010_0004, 32'h8010_0008,
             32'h8010_0000, 32'h8010_000c, 32'h8010_0008};
    foreach (set3[i]) cyc(1'b1, set3[i], 1'b0, "R2 fill");
    // R8: retire in the trigger cycle, retires and a trigger during the scan
    cyc(1'b1, 32'hdead_0000, 1'b1, "R8 trig+retire");
    cyc(1'b1, 32'hdead_0004, 1'b0, "R8 retire in scan");
    cyc(1'b1, 32'hdead_0004, 1'b1, "R8 trig in scan");
    cyc(1'b1, 32'hdead_0004, 1'b0, "R8 retire in scan");
    wait_done("R2 partial");
    chk(h_cnt == 3 && h_size == 7, "R7", "partial snapshot size", h_size, 7);
    // R8: second trigger without retires gives the same result
    cyc(1'b0, '0, 1'b1, "R8 retrigger");
    wait_done("R8 retrigger");

    // R6: tie between X and Y, X is older
    do_reset();
    cyc(1'b1, 32'h0000_1110, 1'b0, "R6");
    cyc(1'b1, 32'h0000_2220, 1'b0, "R6");
    cyc(1'b1, 32'h0000_2220, 1'b0, "R6");
    cyc(1'b1, 32'h0000_1110, 1'b0, "R6");
    cyc(1'b1, 32'h0000_3330, 1'b0, "R6");
    cyc(1'b0, '0, 1'b1, "R6 trig");
    wait_done("R6 tie");
    chk(hot_pc == 32'h0000_1110, "R6", "tie winner is oldest", hot_pc, 32'h0000_1110);

    // R1 / R4: old history overwritten by a two-address loop
    do_reset();
    for (int i = 0; i < 40; i++) cyc(1'b1, 32'h0000_1000, 1'b0, "R1 old");
    for (int i = 0; i < 300; i++) cyc(1'b1, (i % 2) ? 32'h8010_0014 : 32'h8010_0010, 1'b0, "R1 loop");
    cyc(1'b0, '0, 1'b1, "R4 trig");
    wait_done("R4 loop");
    chk(hot_cnt == 9'd128 && hot_size == 9'd256, "R4", "loop 128 of 256", hot_cnt, 128);
    chk(hot_pc == 32'h8010_0010, "R1", "loop hot pc", hot_pc, 32'h8010_0010);

    // R1 / R2: irregular full ring after wrap
    for (int i = 0; i < 300; i++)
      cyc(1'b1, 32'h8020_0000 + 32'(((i * i * 7 + 3 * i) % 23) * 4), 1'b0, "R1 mix");
    cyc(1'b0, '0, 1'b1, "R2 trig");
    wait_done("R2 mix");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule